// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block decodes the 16-bit address bus of a small 8-bit controller into one of four targets: a 512-byte internal RAM, a 128-byte control/status register block, an internal ROM fixed at the top of the address space, or the external bus. The RAM and the register block each start on a 4 KiB boundary. Their bases come from an 8-bit placement register that software programs during start-up.

The placement register sits inside the register block, so its address moves whenever the block moves. In normal mode it accepts only one write, and only within a short window counted in bus clock cycles after reset. After that it can still be read but cannot be changed. When the special-mode input is high, every write to it is accepted.

The decoder samples the address on each bus clock edge. It presents one registered one-hot select per access.

Top module: `memmap_decode`

## Requirements
- R1: While reset is high, and on the first cycle after it, the placement register reads 0x01 and all four selects are low.
- R2: The RAM select is chosen for the 512 addresses starting at {placement[7:4], 12'h000}.
- R3: The register-block select is chosen for the 128 addresses starting at {placement[3:0], 12'h000}. The placement register is written at offset 0x3D of that block.
- R4: The ROM select is chosen for 0xC000 to 0xFFFF, but only when rom_en is high. With rom_en low those addresses select the external bus.
- R5: Where regions overlap, the register block takes precedence over RAM and ROM, and RAM takes precedence over ROM.
- R6: The external select is high only when no internal region claims the address. At most one select is high in any cycle.
- R7: The selects are registered: they reflect the address and strobes of the previous clock edge. All four are low after an edge on which neither rd_en nor wr_en was high.
- R8: In normal mode, a write to the placement register is accepted on any of the first 64 clock edges after reset is released.
- R9: In normal mode, once one write has been accepted, any later write is ignored.
- R10: In normal mode, a write on the 65th or any later edge after reset release is ignored, even if no write was made before.
- R11: With special_mode high, every write to the placement register is accepted, whatever the cycle count and however many writes came before.
- R12: map_rdata always shows the placement register. An accepted write appears there from the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| special_mode | input | 1 | High lifts the write-once and window limits |
| rom_en | input | 1 | High maps the internal ROM |
| sel_regs | output | 1 | Register-block select (registered) |
| sel_ram | output | 1 | RAM select (registered) |
| sel_rom | output | 1 | ROM select (registered) |
| sel_ext | output | 1 | External-bus select (registered) |
| map_rdata | output | 8 | Current placement register value |

## Verification
A wrong window count or a stuck write-once flag shows up as a change on map_rdata one edge after a write that should be refused, or as no change after a write that should be accepted. A bad base value or a wrong precedence shows up as the wrong select one edge after the address is presented. The relocated register and RAM ranges are probed at both ends and one address past each end. Overlaps are placed against the other regions to exercise the precedence rules.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    TGT_REGS = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_ROM  = 2'd2,
    TGT_EXT  = 2'd3
  } target_e;

  typedef struct packed {
    logic regs;
    logic ram;
    logic rom;
    logic ext;
  } sel_t;

  function automatic sel_t target_to_sel(input target_e tgt, input logic active);
    sel_t s;
    s = '0;
    if (active) begin
      unique case (tgt)
        TGT_REGS: s.regs = 1'b1;
        TGT_RAM:  s.ram  = 1'b1;
        TGT_ROM:  s.rom  = 1'b1;
        default:  s.ext  = 1'b1;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/mm_region_hit.sv
module mm_region_hit #(
  parameter int ADDR_W    = 16,
  parameter int BASE_W    = 4,
  parameter int SPAN_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  output logic              hit
);
  localparam int GAP_HI = ADDR_W - BASE_W - 1;

  logic base_eq;
  assign base_eq = (addr[ADDR_W-1 -: BASE_W] == base);

  generate
    if (SPAN_LOG2 > GAP_HI) begin : g_full_page
      assign hit = base_eq;
    end else begin : g_sub_page
      assign hit = base_eq && (addr[GAP_HI:SPAN_LOG2] == '0);
    end
  endgenerate
endmodule

// File: rtl/mm_map_reg.sv
module mm_map_reg #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WINDOW    = 64,
  parameter int RESET_MAP = 8'h01,
  parameter int OFFSET    = 'h3D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                special_mode,
  output logic [DATA_W-1:0]   map_q
);
  localparam int BASE_W = DATA_W / 2;
  localparam int OFF_W  = ADDR_W - BASE_W;
  localparam int CNT_W  = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW);
  localparam logic [OFF_W-1:0] OFF_V   = OFF_W'(OFFSET);

  logic [CNT_W-1:0] cyc_cnt;
  logic             written;
  logic             addr_hit;
  logic             window_open;
  logic             accept;

  assign addr_hit    = (addr == {map_q[BASE_W-1:0], OFF_V});
  assign window_open = (cyc_cnt < CNT_MAX);
  assign accept      = wr_en && addr_hit &&
                       (special_mode || (!written && window_open));

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt <= '0;
    end else if (window_open) begin
      cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q   <= DATA_W'(RESET_MAP);
      written <= 1'b0;
    end else if (accept) begin
      map_q   <= wdata;
      written <= 1'b1;
    end
  end
endmodule

// File: rtl/mm_select_arb.sv
module mm_select_arb
  import memmap_pkg::*;
(
  input  logic regs_hit,
  input  logic ram_hit,
  input  logic rom_hit,
  input  logic rom_en,
  input  logic active,
  output sel_t sel
);
  target_e tgt;

  always_comb begin
    if (regs_hit)               tgt = TGT_REGS;
    else if (ram_hit)           tgt = TGT_RAM;
    else if (rom_hit && rom_en) tgt = TGT_ROM;
    else                        tgt = TGT_EXT;
    sel = target_to_sel(tgt, active);
  end
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 512,
  parameter int REG_BYTES = 128,
  parameter int ROM_BASE  = 'hC000,
  parameter int ROM_BYTES = 'h4000,
  parameter int MAP_OFS   = 'h3D,
  parameter int WINDOW    = 64,
  parameter int RESET_MAP = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              special_mode,
  input  logic              rom_en,
  output logic              sel_regs,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic              sel_ext,
  output logic [7:0]        map_rdata
);
  localparam int BASE_W    = DATA_W / 2;
  localparam int RAM_LOG2  = $clog2(RAM_BYTES);
  localparam int REG_LOG2  = $clog2(REG_BYTES);
  localparam logic [ADDR_W:0] ROM_LO = (ADDR_W+1)'(ROM_BASE);
  localparam logic [ADDR_W:0] ROM_HI = (ADDR_W+1)'(ROM_BASE + ROM_BYTES);

  logic [DATA_W-1:0] map_q;
  logic              regs_hit, ram_hit, rom_hit;
  logic [ADDR_W:0]   addr_x;
  sel_t              sel_d, sel_q;

  mm_map_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW(WINDOW),
    .RESET_MAP(RESET_MAP), .OFFSET(MAP_OFS)
  ) map_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .special_mode(special_mode), .map_q(map_q)
  );

  mm_region_hit #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SPAN_LOG2(REG_LOG2)) regs_hit_i (
    .addr(addr), .base(map_q[BASE_W-1:0]), .hit(regs_hit)
  );

  mm_region_hit #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SPAN_LOG2(RAM_LOG2)) ram_hit_i (
    .addr(addr), .base(map_q[DATA_W-1:BASE_W]), .hit(ram_hit)
  );

  assign addr_x  = {1'b0, addr};
  assign rom_hit = (addr_x >= ROM_LO) && (addr_x < ROM_HI);

  mm_select_arb arb_i (
    .regs_hit(regs_hit), .ram_hit(ram_hit), .rom_hit(rom_hit),
    .rom_en(rom_en), .active(rd_en | wr_en), .sel(sel_d)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end

  assign sel_regs  = sel_q.regs;
  assign sel_ram   = sel_q.ram;
  assign sel_rom   = sel_q.rom;
  assign sel_ext   = sel_q.ext;
  assign map_rdata = map_q;
endmodule

// File: rtl/memmap_decode_chk.sv
module memmap_decode_chk #(
  parameter int WINDOW    = 64,
  parameter int RESET_MAP = 8'h01
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       wr_en,
  input logic       special_mode,
  input logic       rom_en,
  input logic       sel_regs,
  input logic       sel_ram,
  input logic       sel_rom,
  input logic       sel_ext,
  input logic [7:0] map_rdata
);
  localparam int CW = $clog2(WINDOW + 2);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < CW'(WINDOW + 1)) since_rst <= since_rst + 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (map_rdata == 8'(RESET_MAP) &&
             !sel_regs && !sel_ram && !sel_rom && !sel_ext)); // R1

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_regs, sel_ram, sel_rom, sel_ext})); // R6

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    !(rd_en || wr_en) |=> !(sel_regs || sel_ram || sel_rom || sel_ext)); // R7

  AST_ROM_GATED: assert property (@(posedge clk) disable iff (rst)
    !rom_en |=> !sel_rom); // R4

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(map_rdata)); // R12

  AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= CW'(WINDOW) && !special_mode) |=> $stable(map_rdata)); // R10
endmodule

bind memmap_decode memmap_decode_chk #(.WINDOW(WINDOW), .RESET_MAP(RESET_MAP)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
  .special_mode(special_mode), .rom_en(rom_en),
  .sel_regs(sel_regs), .sel_ram(sel_ram), .sel_rom(sel_rom),
  .sel_ext(sel_ext), .map_rdata(map_rdata)
);

// File: tb/memmap_decode_tb.sv
module memmap_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        special_mode = 1'b0, rom_en = 1'b1;
  logic        sel_regs, sel_ram, sel_rom, sel_ext;
  logic [7:0]  map_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  memmap_decode dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .special_mode(special_mode), .rom_en(rom_en),
    .sel_regs(sel_regs), .sel_ram(sel_ram), .sel_rom(sel_rom),
    .sel_ext(sel_ext), .map_rdata(map_rdata)
  );

  // {addr, rd, rom_en, expected {regs,ram,rom,ext}} with placement = 0x23
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {16'h3000, 1'b1, 1'b1, 4'b1000},  // R3 low end
    {16'h307F, 1'b1, 1'b1, 4'b1000},  // R3 high end
    {16'h3080, 1'b1, 1'b1, 4'b0001},  // R3 past end
    {16'h303D, 1'b1, 1'b1, 4'b1000},  // R3 placement register
    {16'h2000, 1'b1, 1'b1, 4'b0100},  // R2 low end
    {16'h21FF, 1'b1, 1'b1, 4'b0100},  // R2 high end
    {16'h2200, 1'b1, 1'b1, 4'b0001},  // R2 past end
    {16'h0000, 1'b1, 1'b1, 4'b0001},  // R2 old RAM base gone
    {16'h1000, 1'b1, 1'b1, 4'b0001},  // R3 old block base gone
    {16'hC000, 1'b1, 1'b1, 4'b0010},  // R4
    {16'hFFFF, 1'b1, 1'b1, 4'b0010},  // R4
    {16'hBFFF, 1'b1, 1'b1, 4'b0001},  // R6
    {16'hC000, 1'b1, 1'b0, 4'b0001},  // R4 rom disabled
    {16'hFFFF, 1'b1, 1'b0, 4'b0001},  // R4 rom disabled
    {16'h2000, 1'b0, 1'b1, 4'b0000}   // R7 no strobe
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sels();
    return {sel_regs, sel_ram, sel_rom, sel_ext};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [3:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, 16'(sels()), 16'(exp));
  endtask

  task automatic map_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 map", 16'(map_rdata), 16'h01);
    chk("R1 sel", 16'(sels()), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 map after release", 16'(map_rdata), 16'h01);
    rd_check("R2 default RAM", 16'h0000, 4'b0100);
    rd_check("R3 default block", 16'h1000, 4'b1000);

    // R8 first write inside window, R12 visible
    map_write(16'h103D, 8'h23);
    chk("R8 R12 write accepted", 16'(map_rdata), 16'h23);
    // R9 second write ignored
    map_write(16'h303D, 8'h45);
    chk("R9 second write", 16'(map_rdata), 16'h23);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][21:6]; rd_en = VEC[i][5]; rom_en = VEC[i][4];
      @(negedge clk);
      rd_en = 1'b0;
      chk($sformatf("R2-R7 vector %0d", i), 16'(sels()), 16'(VEC[i][3:0]));
    end
    rom_en = 1'b1;

    // R8 boundary: write on edge 64 accepted
    do_reset();
    repeat (63) @(negedge clk);
    addr = 16'h103D; wdata = 8'h5A; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 edge 64", 16'(map_rdata), 16'h5A);

    // R10 boundary: write on edge 65 rejected
    do_reset();
    repeat (64) @(negedge clk);
    addr = 16'h103D; wdata = 8'hA5; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 edge 65", 16'(map_rdata), 16'h01);

    // R11 special mode: repeated writes after window
    special_mode = 1'b1;
    map_write(16'h103D, 8'h11);
    chk("R11 first special write", 16'(map_rdata), 16'h11);
    // R5 overlap: block and RAM both at 0x1000
    rd_check("R5 block over RAM", 16'h1000, 4'b1000);
    rd_check("R5 RAM beyond block", 16'h1080, 4'b0100);
    rd_check("R5 RAM end", 16'h11FF, 4'b0100);
    rd_check("R6 past RAM", 16'h1200, 4'b0001);

    map_write(16'h103D, 8'hCD);
    chk("R11 second special write", 16'(map_rdata), 16'hCD);
    rd_check("R5 RAM over ROM", 16'hC000, 4'b0100);
    rd_check("R5 ROM past RAM", 16'hC200, 4'b0010);
    rd_check("R5 block over ROM", 16'hD000, 4'b1000);
    rd_check("R5 ROM past block", 16'hD080, 4'b0010);
    rd_check("R5 block over ROM at 0x3D", 16'hD03D, 4'b1000);
    special_mode = 1'b0;
    map_write(16'hD03D, 8'h01);
    chk("R10 normal write after window", 16'(map_rdata), 16'hCD);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule